// File: doc/BRIEF.md
# CAN Standard Frame Transmitter

This block turns one standard-format CAN data or remote frame into a serial bit stream on a single transmit line. It sends one bit on each bit-time strobe from the bit-timing logic. A controller presents an 11-bit identifier, a remote-request flag, a 4-bit length code and eight data bytes, then pulses start while the block is idle. The block holds busy high until the whole frame and its inter-frame gap have been sent.

The block builds the frame in this order: a dominant start bit, then the header, then the data bytes, then a 15-bit CRC. It applies bit stuffing to all of these. It then sends the unstuffed recessive tail and samples the receive line during the acknowledge slot. When the frame finishes, it gives a one-cycle pulse that reports whether any node acknowledged the frame.

Top module: `can_frame_tx`

## Requirements
- R1: After reset, and whenever busy_o is low, tx_o is 1 (recessive) and busy_o, done_o and ack_err_o are 0. Logic 0 is dominant.
- R2: start_i is accepted only in a cycle where busy_o is low, and busy_o rises on the following edge. A start_i that arrives while busy_o is high, including during the final strobe of a frame, has no effect on the bits sent and does not start a new frame.
- R3: The unstuffed frame begins with the following fields, each MSB first:
  - one 0 bit;
  - id_i (11 bits);
  - the request bit, equal to rtr_i (0 for a data frame, 1 for a remote frame);
  - two 0 reserved bits;
  - dlc_i (4 bits).
- R4: The number of data bytes is min(dlc_i, 8) when rtr_i is 0 and zero when rtr_i is 1. The byte sent first is data_i[63:56], and each byte goes out MSB first. The DLC field always carries the dlc_i value as given.
- R5: A 15-bit CRC is sent MSB first straight after the data. It uses generator 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1) and starts at zero. It covers the unstuffed bits from the start bit through the last data bit.
- R6: From the start bit through the last CRC bit, five equal consecutive bits on the line are followed by one bit of the opposite value. Inserted bits count toward the next run. A stuff bit that falls due after the last CRC bit is sent before the CRC delimiter.
- R7: After the CRC, the block sends 13 recessive bits with no stuffing: the CRC delimiter, the ACK slot, the ACK delimiter, seven end-of-frame bits and three intermission bits.
- R8: rx_i is sampled on the strobe that ends the ACK slot. On the strobe after the last intermission bit, busy_o falls and exactly one of done_o (rx_i was 0) or ack_err_o (rx_i was 1) is high for one cycle.
- R9: tx_o changes only on an edge where bit_tick_i is high. Each strobe while busy sends exactly one line bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe that marks each bit boundary |
| start_i | input | 1 | Request to send a frame; taken only while idle |
| id_i | input | 11 | Frame identifier |
| rtr_i | input | 1 | 1 = remote request frame, 0 = data frame |
| dlc_i | input | 4 | Data length code |
| data_i | input | 64 | Data bytes; [63:56] is sent first |
| rx_i | input | 1 | Receive line, sampled in the ACK slot |
| tx_o | output | 1 | Transmit line |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse: frame acknowledged |
| ack_err_o | output | 1 | One-cycle pulse: ACK slot stayed recessive |

## Verification
Two functions can fall in the same cycle: a new start request, and the final strobe that retires a frame and raises its outcome pulse. The bench holds start_i high from the last intermission bit through the retiring strobe. It then checks three things: busy_o stays low afterwards, tx_o stays recessive, and the outcome pulse lasts one cycle. The same hold-over pattern is also applied in the middle of a frame, with a different identifier on the inputs, and the bit stream must still match the frame that was latched. The reference stream, with CRC and stuffing, is recomputed in the bench for each vector. The vectors include long runs of 0s and 1s, a remote frame, and a length code above eight.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  // state names the next bit to be emitted
  typedef enum logic [3:0] {
    ST_IDLE, ST_PAY, ST_CRC, ST_CDEL, ST_ACK, ST_ADEL, ST_EOF, ST_IFS, ST_FIN
  } tx_state_e;
endpackage

// File: rtl/can_crc15.sv
module can_crc15 #(
  parameter int             W    = 15,
  parameter logic [W-1:0]   POLY = 'h4599
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic shf_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [W-1:0] crc_q;
  logic         fb;

  assign fb    = bit_i ^ crc_q[W-1];
  assign msb_o = crc_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (upd_i) crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else if (shf_i) crc_q <= {crc_q[W-2:0], 1'b0};  // reuse as output shifter
  end
endmodule

// File: rtl/can_stuff_mon.sv
module can_stuff_mon #(
  parameter int RUN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic due_o,
  output logic fill_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;
  logic          last_q;

  assign due_o  = (cnt_q == CW'(RUN));
  assign fill_o = ~last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q  <= '0;
      last_q <= 1'b1;
    end else if (adv_i) begin
      last_q <= bit_i;
      if (bit_i == last_q && cnt_q != '0 && cnt_q < CW'(RUN)) cnt_q <= cnt_q + 1'b1;
      else                                                   cnt_q <= CW'(1);
    end
  end
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int             ID_W      = 11,
  parameter int             DLC_W     = 4,
  parameter int             MAX_BYTES = 8,
  parameter int             CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 'h4599,
  parameter int             STUFF_RUN = 5,
  parameter int             EOF_LEN   = 7,
  parameter int             IFS_LEN   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bit_tick_i,
  input  logic                   start_i,
  input  logic [ID_W-1:0]        id_i,
  input  logic                   rtr_i,
  input  logic [DLC_W-1:0]       dlc_i,
  input  logic [8*MAX_BYTES-1:0] data_i,
  input  logic                   rx_i,
  output logic                   tx_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   ack_err_o
);
  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int HDR_W  = 1 + ID_W + 1 + 2 + DLC_W;
  localparam int FRM_W  = HDR_W + DATA_W;
  localparam int CNT_W  = $clog2(FRM_W + 1);
  localparam int NB_W   = $clog2(MAX_BYTES + 1);

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRM_W-1:0]  frm_q;
  logic              tx_q, ack_seen_q, done_q, err_q;

  logic [NB_W-1:0]   nbytes;
  logic [CNT_W-1:0]  pay_len;
  logic              accept, stuff_zone, stuff_due, stuff_fill, do_stuff;
  logic              crc_msb, nbit, emit_bit, last_cnt;

  // payload length from the request fields
  always_comb begin
    if (rtr_i)                          nbytes = '0;
    else if (int'(dlc_i) > MAX_BYTES)   nbytes = NB_W'(MAX_BYTES);
    else                                nbytes = NB_W'(dlc_i);
  end
  assign pay_len = CNT_W'(HDR_W + 8 * int'(nbytes));

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign stuff_zone = (state_q == ST_PAY) || (state_q == ST_CRC) || (state_q == ST_CDEL);
  assign do_stuff   = bit_tick_i && stuff_zone && stuff_due;
  assign last_cnt   = (cnt_q == CNT_W'(1));

  always_comb begin
    case (state_q)
      ST_PAY:  nbit = frm_q[FRM_W-1];
      ST_CRC:  nbit = crc_msb;
      default: nbit = 1'b1;
    endcase
  end
  assign emit_bit = do_stuff ? stuff_fill : nbit;

  can_crc15 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .upd_i  (bit_tick_i && !do_stuff && state_q == ST_PAY),
    .shf_i  (bit_tick_i && !do_stuff && state_q == ST_CRC),
    .bit_i  (frm_q[FRM_W-1]),
    .msb_o  (crc_msb)
  );

  can_stuff_mon #(.RUN(STUFF_RUN)) u_stuff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .adv_i  (bit_tick_i && (do_stuff || state_q == ST_PAY || state_q == ST_CRC)),
    .bit_i  (emit_bit),
    .due_o  (stuff_due),
    .fill_o (stuff_fill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      frm_q      <= '0;
      tx_q       <= 1'b1;
      ack_seen_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          frm_q   <= {1'b0, id_i, rtr_i, 2'b00, dlc_i, data_i};
          cnt_q   <= pay_len;
          state_q <= ST_PAY;
        end
      end else if (bit_tick_i) begin
        tx_q <= emit_bit;
        if (!do_stuff) begin
          unique case (state_q)
            ST_PAY: begin
              frm_q <= {frm_q[FRM_W-2:0], 1'b0};
              if (last_cnt) begin
                state_q <= ST_CRC;
                cnt_q   <= CNT_W'(CRC_W);
              end else cnt_q <= cnt_q - 1'b1;
            end
            ST_CRC: begin
              if (last_cnt) state_q <= ST_CDEL;
              else          cnt_q   <= cnt_q - 1'b1;
            end
            ST_CDEL: state_q <= ST_ACK;
            ST_ACK:  state_q <= ST_ADEL;
            ST_ADEL: begin
              // line currently holds the ACK slot
              ack_seen_q <= !rx_i;
              state_q    <= ST_EOF;
              cnt_q      <= CNT_W'(EOF_LEN);
            end
            ST_EOF: begin
              if (last_cnt) begin
                state_q <= ST_IFS;
                cnt_q   <= CNT_W'(IFS_LEN);
              end else cnt_q <= cnt_q - 1'b1;
            end
            ST_IFS: begin
              if (last_cnt) state_q <= ST_FIN;
              else          cnt_q   <= cnt_q - 1'b1;
            end
            ST_FIN: begin
              state_q <= ST_IDLE;
              done_q  <= ack_seen_q;
              err_q   <= !ack_seen_q;
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign tx_o      = tx_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign ack_err_o = err_q;
endmodule

// File: rtl/can_frame_tx_chk.sv
module can_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic start_i,
  input logic tx_o,
  input logic busy_o,
  input logic done_o,
  input logic ack_err_o
);
  assert_idle_recessive_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  assert_accept_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_one_outcome_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && ack_err_o));

  assert_outcome_ends_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || ack_err_o) |-> $fell(busy_o));

  assert_outcome_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || ack_err_o) |=> !(done_o || ack_err_o));

  assert_tx_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_tick_i |=> $stable(tx_o));
endmodule

bind can_frame_tx can_frame_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .start_i    (start_i),
  .tx_o       (tx_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ack_err_o  (ack_err_o)
);

// File: tb/tb_can_frame_tx.sv
`timescale 1ns/1ps
module tb_can_frame_tx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        start_i = 1'b0;
  logic [10:0] id_i = '0;
  logic        rtr_i = 1'b0;
  logic [3:0]  dlc_i = '0;
  logic [63:0] data_i = '0;
  logic        rx_i = 1'b1;
  logic        tx_o, busy_o, done_o, ack_err_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tdiv   = 0;

  logic exp_q [0:255];
  logic got_q [0:255];
  int   exp_len, ack_idx;

  always #2 clk = ~clk;

  can_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(tick), .start_i(start_i),
    .id_i(id_i), .rtr_i(rtr_i), .dlc_i(dlc_i), .data_i(data_i), .rx_i(rx_i),
    .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o), .ack_err_o(ack_err_o)
  );

  // strobe every third cycle
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // {id, rtr, dlc, data, ack_given}
  localparam int NV = 6;
  localparam logic [80:0] VECS [NV] = '{
    {11'h123, 1'b0, 4'd2,  64'hA55A_0000_0000_0000, 1'b1},
    {11'h000, 1'b0, 4'd1,  64'h0000_0000_0000_0000, 1'b1},  // long dominant runs, R6
    {11'h7F0, 1'b1, 4'd4,  64'hDEAD_BEEF_0000_0000, 1'b1},  // remote frame, R4
    {11'h555, 1'b0, 4'd8,  64'h0123_4567_89AB_CDEF, 1'b0},  // no ACK, R8
    {11'h0FF, 1'b0, 4'd15, 64'hFFFF_FFFF_0000_0000, 1'b1},  // DLC clamp, R4
    {11'h3A1, 1'b0, 4'd0,  64'h0,                   1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference stream from the requirements
  task automatic build(input logic [10:0] id, input logic rtr, input logic [3:0] dlc, input logic [63:0] d);
    logic        u [0:127];
    int          n, nb, run;
    logic [14:0] crc;
    logic        fb, last;
    n = 0;
    u[n] = 1'b0; n++;
    for (int i = 10; i >= 0; i--) begin u[n] = id[i]; n++; end
    u[n] = rtr; n++;
    u[n] = 1'b0; n++;
    u[n] = 1'b0; n++;
    for (int i = 3; i >= 0; i--) begin u[n] = dlc[i]; n++; end
    nb = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
    for (int i = 0; i < nb * 8; i++) begin u[n] = d[63-i]; n++; end
    crc = '0;
    for (int i = 0; i < n; i++) begin
      fb  = u[i] ^ crc[14];
      crc = {crc[13:0], 1'b0};
      if (fb) crc = crc ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) begin u[n] = crc[i]; n++; end
    exp_len = 0; run = 0; last = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (run == 5) begin
        exp_q[exp_len] = ~last; exp_len++;
        last = ~last; run = 1;
      end
      if (u[i] == last) run++;
      else begin run = 1; last = u[i]; end
      exp_q[exp_len] = u[i]; exp_len++;
    end
    if (run == 5) begin exp_q[exp_len] = ~last; exp_len++; end
    exp_q[exp_len] = 1'b1; exp_len++;
    ack_idx = exp_len;
    for (int i = 0; i < 12; i++) begin exp_q[exp_len] = 1'b1; exp_len++; end
  endtask

  task automatic run_frame(input logic [80:0] v, input bit hold_mid, input bit hold_end);
    int   k, mism, first_bad, unstable, guard;
    bit   t, ack_en;
    logic last_tx;
    ack_en = v[0];
    build(v[80:70], v[69], v[68:65], v[64:1]);
    @(negedge clk);
    id_i = v[80:70]; rtr_i = v[69]; dlc_i = v[68:65]; data_i = v[64:1];
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    k = 0; unstable = 0; guard = 0; last_tx = 1'b1;
    while (guard < 4000) begin
      guard++;
      @(posedge clk); t = tick;
      @(negedge clk);
      if (t) begin
        if (!busy_o) break;
        got_q[k] = tx_o; last_tx = tx_o; k++;
        rx_i = (ack_en && (k - 1) == ack_idx) ? 1'b0 : 1'b1;
      end else if (busy_o && tx_o !== last_tx) unstable++;
      if (hold_mid) begin
        start_i = (k >= 10 && k < 20);
        id_i    = ~v[80:70];
        rtr_i   = ~v[69];
      end
      if (hold_end && k >= exp_len) start_i = 1'b1;
    end
    chk(k == exp_len, "R7", "frame length in bits", k, exp_len);
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_len && i < k; i++)
      if (got_q[i] !== exp_q[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    chk(mism == 0, "R3 R4 R5 R6 R7", "bit stream mismatches (first at index shown)", first_bad, -1);
    chk(done_o == ack_en && ack_err_o == !ack_en, "R8", "outcome {done,ack_err}",
        int'({done_o, ack_err_o}), int'({ack_en, !ack_en}));
    chk(unstable == 0, "R9", "tx changes between strobes", unstable, 0);
    start_i = 1'b0; rx_i = 1'b1;
    @(negedge clk);
    chk(!done_o && !ack_err_o, "R8", "outcome pulse width", int'({done_o, ack_err_o}), 0);
    chk(!busy_o && tx_o, "R2", "idle after frame {busy,tx}", int'({busy_o, tx_o}), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(tx_o && !busy_o && !done_o && !ack_err_o, "R1", "reset state {tx,busy,done,err}",
        int'({tx_o, busy_o, done_o, ack_err_o}), 8);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_o && !busy_o, "R1", "idle after reset {tx,busy}", int'({tx_o, busy_o}), 2);

    for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0, 1'b0);

    // R2: start held mid-frame with other fields
    run_frame(VECS[0], 1'b1, 1'b0);
    // R2: start held across the retiring strobe
    run_frame(VECS[3], 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(!busy_o && tx_o, "R2", "no restart after end-of-frame start {busy,tx}", int'({busy_o, tx_o}), 1);

    // R1: reset in the middle of a frame
    @(negedge clk);
    id_i = 11'h000; rtr_i = 1'b0; dlc_i = 4'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (40) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(tx_o && !busy_o, "R1", "reset mid-frame {tx,busy}", int'({tx_o, busy_o}), 2);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(VECS[1], 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule